// File: doc/BRIEF.md
# Bus-Mapped BCD Calendar Clock

This block keeps time of day and calendar date in packed BCD and shows them as the eight highest bytes of a 32K x 8 byte address space. A one-cycle pulse on `tick_1hz` advances the internal counters by one second. The counters handle minute, hour and day carries, months of 28 to 31 days, leap years and year wrap.

The bus never touches the counters directly. It reads and writes a visible copy that the block refreshes from the counters on every tick. A control byte can freeze that copy for a stable read. It can also hold the copy while software edits it and then load the edited copy into the counters. A stop bit halts counting. A century flag flips at the 99 to 00 year wrap, but only when it is enabled.

Any address below the top eight bytes belongs to the surrounding memory. For those addresses `clk_sel` is low, the block reads as zero and it ignores writes.

Top module: `bcd_rtc_shadow`

## Requirements
- R1: Bytes 0x7FF8..0x7FFF decode in this order: control, seconds, minutes, hours, day, date, month, year. `clk_sel` is high only for these bytes. Every other address reads 0x00 and writes there change nothing. After reset the bytes read 00,00,00,00,01,01,01,00 in that order.
- R2: Seconds and minutes count 00..59 and hours 00..23, in packed BCD. Each wrap to 00 carries into the next field. A carry out of hours advances both day and date.
- R3: Date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in all other months except 02. A date wrap advances the month.
- R4: In month 02 the date wraps after 29 when the BCD year is a multiple of 4, 00 included, and after 28 otherwise.
- R5: Day of week (bits 2:0 of the day byte) wraps from 7 to 1. Month wraps from 12 to 01 and advances the year. Year wraps from 99 to 00.
- R6: When no freeze is active, each tick copies the updated counters into all seven visible time bytes at once. The new values can be read right after the tick edge.
- R7: Control bit 6 freezes the visible time bytes while it is 1. After it is cleared, the bytes keep their frozen values until the next tick, which shows the running count.
- R8: Control bit 7 also freezes the visible bytes. Bus writes to the time bytes edit the copy. Writing the control byte with bit 7 = 0 while bit 7 is 1 loads the copy into the counters, and counting continues from those values.
- R9: Bit 7 of the seconds byte is a stop flag that takes effect at any time. While it is 1 the counters do not advance. The first tick after it is cleared advances the count.
- R10: In the day byte, bit 5 enables the century flag and bit 4 holds it. With bit 5 = 1 the flag toggles on the 99 to 00 year wrap. With bit 5 = 0 the flag keeps its value.
- R11: The century flag accepts a write only while control bit 7 is 1. The enable bit accepts a write at any time.
- R12: Bits outside the time fields read back as written and do not alter counting. These are minutes bit 7, hours bits 7:6, day bits 7, 6 and 3, date bits 7:6, month bits 7:5 and control bits 5:0.
- R13: A loaded out-of-range BCD value never stalls a field. A value at or above the field maximum wraps to the field minimum and carries. A low digit of 9 or more rolls into the tens digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| addr | input | 15 | Byte address |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| clk_sel | output | 1 | High when `addr` is one of the clock bytes |

## Verification
The bench loads boundary dates and takes one tick for each. These cover the end of 30-day and 31-day months, February in leap and common years (year 00 and year 12 included), and the year-end wrap. A wrong length table would land on date 31 or 29 instead of 01. A wrong leap test would skip 29 February or invent it. The bench also drives each freeze bit together with several ticks. A design that leaked refreshes through a freeze, or lost ticks during one, would read wrong seconds after release. Further directed cases cover a century flag that flips only with its enable set, a flag write refused without the load bit, reserved bits that must survive refreshes, and out-of-range values such as seconds 5A or month 13. A design that compares for equality instead of "at or above" would run away or stall on those out-of-range values.

// File: rtl/bcd_rtc_shadow.sv
module bcd_rtc_shadow #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              clk_sel
);
  localparam int OFF_CTL = 0, OFF_SEC = 1, OFF_MIN = 2, OFF_HR = 3,
                 OFF_DAY = 4, OFF_DATE = 5, OFF_MON = 6, OFF_YR = 7;

  function automatic logic [7:0] fmask(input int k);
    case (k)
      OFF_SEC, OFF_MIN: fmask = 8'h7F;
      OFF_HR, OFF_DATE: fmask = 8'h3F;
      OFF_DAY:          fmask = 8'h07;
      OFF_MON:          fmask = 8'h1F;
      default:          fmask = 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] xmask(input int k);
    case (k)
      OFF_MIN:          xmask = 8'h80;
      OFF_HR, OFF_DATE: xmask = 8'hC0;
      OFF_DAY:          xmask = 8'hC8;
      OFF_MON:          xmask = 8'hE0;
      default:          xmask = 8'h00;
    endcase
  endfunction

  function automatic logic [8:0] bump(input logic [7:0] v, input logic [7:0] hi,
                                      input logic [7:0] lo);
    if (v >= hi)            bump = {1'b1, lo};
    else if (v[3:0] >= 4'd9) bump = {1'b0, v[7:4] + 4'd1, 4'd0};
    else                    bump = {1'b0, v + 8'd1};
  endfunction

  logic       ctl_w, ctl_r, stop, c_ceb, c_cb, v_cb;
  logic [5:0] cal;
  logic [7:0] cnt  [1:7];
  logic [7:0] vis  [1:7];
  logic [7:0] xtra [1:7];
  logic [7:0] nxt  [1:7];
  logic       nxt_cb;

  logic [2:0] off;
  assign clk_sel = &addr[ADDR_W-1:3];
  assign off     = addr[2:0];

  logic wr_hit, ld, adv, frozen;
  assign wr_hit = wr_en && clk_sel;
  assign ld     = wr_hit && off == 3'(OFF_CTL) && ctl_w && !wdata[7];
  assign adv    = tick_1hz && !stop;
  assign frozen = ctl_r || ctl_w;

  logic       leap;
  logic [7:0] dmax;
  assign leap = cnt[OFF_YR][4] ? (cnt[OFF_YR][3:0] == 4'd2 || cnt[OFF_YR][3:0] == 4'd6)
                               : (cnt[OFF_YR][3:0] == 4'd0 || cnt[OFF_YR][3:0] == 4'd4 ||
                                  cnt[OFF_YR][3:0] == 4'd8);
  always_comb begin
    case (cnt[OFF_MON])
      8'h02:                      dmax = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dmax = 8'h30;
      default:                    dmax = 8'h31;
    endcase
  end

  logic [8:0] b_s, b_m, b_h, b_dy, b_dt, b_mo, b_y;
  assign b_s  = bump(cnt[OFF_SEC],  8'h59, 8'h00);
  assign b_m  = bump(cnt[OFF_MIN],  8'h59, 8'h00);
  assign b_h  = bump(cnt[OFF_HR],   8'h23, 8'h00);
  assign b_dy = bump(cnt[OFF_DAY],  8'h07, 8'h01);
  assign b_dt = bump(cnt[OFF_DATE], dmax,  8'h01);
  assign b_mo = bump(cnt[OFF_MON],  8'h12, 8'h01);
  assign b_y  = bump(cnt[OFF_YR],   8'h99, 8'h00);

  always_comb begin
    for (int k = 1; k <= 7; k++) nxt[k] = cnt[k];
    nxt_cb = c_cb;
    if (adv) begin
      nxt[OFF_SEC] = b_s[7:0];
      if (b_s[8]) begin
        nxt[OFF_MIN] = b_m[7:0];
        if (b_m[8]) begin
          nxt[OFF_HR] = b_h[7:0];
          if (b_h[8]) begin
            nxt[OFF_DAY]  = b_dy[7:0];
            nxt[OFF_DATE] = b_dt[7:0];
            if (b_dt[8]) begin
              nxt[OFF_MON] = b_mo[7:0];
              if (b_mo[8]) begin
                nxt[OFF_YR] = b_y[7:0];
                if (b_y[8] && c_ceb) nxt_cb = !c_cb;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_w <= 1'b0; ctl_r <= 1'b0; cal <= '0; stop <= 1'b0;
      c_ceb <= 1'b0; c_cb <= 1'b0; v_cb <= 1'b0;
      for (int k = 1; k <= 7; k++) begin
        cnt[k]  <= (k == OFF_DAY || k == OFF_DATE || k == OFF_MON) ? 8'h01 : 8'h00;
        vis[k]  <= (k == OFF_DAY || k == OFF_DATE || k == OFF_MON) ? 8'h01 : 8'h00;
        xtra[k] <= 8'h00;
      end
    end else begin
      if (ld) begin
        for (int k = 1; k <= 7; k++) cnt[k] <= vis[k];
        c_cb <= v_cb;
      end else begin
        for (int k = 1; k <= 7; k++) cnt[k] <= nxt[k];
        c_cb <= nxt_cb;
      end

      if (tick_1hz && !frozen) begin
        for (int k = 1; k <= 7; k++) vis[k] <= nxt[k];
        v_cb <= nxt_cb;
      end

      if (wr_hit) begin
        if (off == 3'(OFF_CTL)) begin
          ctl_w <= wdata[7];
          ctl_r <= wdata[6];
          cal   <= wdata[5:0];
        end else begin
          vis[off]  <= wdata & fmask(int'(off));
          xtra[off] <= wdata & xmask(int'(off));
          if (off == 3'(OFF_SEC)) stop <= wdata[7];
          if (off == 3'(OFF_DAY)) begin
            c_ceb <= wdata[5];
            if (ctl_w) v_cb <= wdata[4];
          end
        end
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (clk_sel) begin
      case (off)
        3'(OFF_CTL): rdata = {ctl_w, ctl_r, cal};
        3'(OFF_SEC): rdata = {stop, vis[OFF_SEC][6:0]};
        3'(OFF_DAY): rdata = (vis[OFF_DAY] & 8'h07) | (xtra[OFF_DAY] & 8'hC8) |
                             {2'b00, c_ceb, v_cb, 4'b0000};
        default:     rdata = (vis[off] & fmask(int'(off))) | (xtra[off] & xmask(int'(off)));
      endcase
    end
  end
endmodule

module bcd_rtc_shadow_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_1hz,
  input logic       wr_en,
  input logic       clk_sel,
  input logic [2:0] off,
  input logic       ld,
  input logic       stop,
  input logic       ctl_r,
  input logic       ctl_w,
  input logic       c_ceb,
  input logic       c_cb,
  input logic       v_cb,
  input logic [7:0] sec_c,
  input logic [7:0] sec_v
);
  a_r9_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !ld && !(wr_en && clk_sel) |=> $stable(sec_c));
  a_r7_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_r || ctl_w) && !(wr_en && clk_sel) |=> $stable(sec_v));
  a_r10_century_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !c_ceb && !ld |=> $stable(c_cb));
  a_r11_cb_guard: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && clk_sel && off == 3'd4 && !ctl_w && !tick_1hz |=> $stable(v_cb));
  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz && !stop && !ld && sec_c == 8'h59 |=> sec_c == 8'h00);
  a_r6_refresh_match: assert property (@(posedge clk) disable iff (!rst_n)
    tick_1hz && !ctl_r && !ctl_w && !ld && !(wr_en && clk_sel) |=> sec_v == sec_c);
  a_r8_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> sec_c == $past(sec_v));
endmodule

bind bcd_rtc_shadow bcd_rtc_shadow_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .clk_sel(clk_sel),
  .off(off), .ld(ld), .stop(stop), .ctl_r(ctl_r), .ctl_w(ctl_w), .c_ceb(c_ceb),
  .c_cb(c_cb), .v_cb(v_cb), .sec_c(cnt[1]), .sec_v(vis[1])
);

// File: tb/bcd_rtc_shadow_tb.sv
module bcd_rtc_shadow_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic [14:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        clk_sel;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  bcd_rtc_shadow dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .clk_sel(clk_sel)
  );

  localparam logic [14:0] A_CTL = 15'h7FF8;
  localparam int NV = 17;
  // start sec,min,hr,day,date,mon,yr then expected after one tick
  localparam logic [111:0] VEC [NV] = '{
    112'h00_00_00_01_01_01_00_01_00_00_01_01_01_00, // R2
    112'h59_00_00_01_01_01_00_00_01_00_01_01_01_00, // R2
    112'h59_59_23_07_15_03_24_00_00_00_01_16_03_24, // R2 R5
    112'h59_59_23_03_30_04_21_00_00_00_04_01_05_21, // R3
    112'h59_59_23_02_31_01_21_00_00_00_03_01_02_21, // R3
    112'h59_59_23_02_30_01_21_00_00_00_03_31_01_21, // R3
    112'h59_59_23_05_28_02_23_00_00_00_06_01_03_23, // R4
    112'h59_59_23_05_28_02_24_00_00_00_06_29_02_24, // R4
    112'h59_59_23_06_29_02_24_00_00_00_07_01_03_24, // R4
    112'h59_59_23_06_28_02_12_00_00_00_07_29_02_12, // R4
    112'h59_59_23_01_28_02_00_00_00_00_02_29_02_00, // R4
    112'h59_59_23_04_31_12_99_00_00_00_05_01_01_00, // R5
    112'h59_59_23_04_30_11_05_00_00_00_05_01_12_05, // R3
    112'h5A_00_00_01_01_01_00_00_01_00_01_01_01_00, // R13
    112'h3A_00_00_01_01_01_00_40_00_00_01_01_01_00, // R13
    112'h59_59_23_01_31_13_07_00_00_00_02_01_01_08, // R13
    112'h59_59_12_02_10_06_30_00_00_13_02_10_06_30  // R2
  };

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  task automatic chk(input string req, input logic [14:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic chk_sel(input string req, input logic [14:0] a, input logic exp);
    @(negedge clk); addr = a; #1;
    checks++;
    if (clk_sel !== exp) begin
      errors++;
      $display("FAIL %s clk_sel addr=%h actual=%b expected=%b", req, a, clk_sel, exp);
    end
  endtask

  task automatic load_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] dy, input logic [7:0] dt, input logic [7:0] mo,
                           input logic [7:0] y);
    wr(A_CTL, 8'h80);
    wr(15'h7FF9, s); wr(15'h7FFA, m); wr(15'h7FFB, h); wr(15'h7FFC, dy);
    wr(15'h7FFD, dt); wr(15'h7FFE, mo); wr(15'h7FFF, y);
    wr(A_CTL, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state and decode
    chk("R1", 15'h7FF8, 8'h00); chk("R1", 15'h7FF9, 8'h00);
    chk("R1", 15'h7FFA, 8'h00); chk("R1", 15'h7FFB, 8'h00);
    chk("R1", 15'h7FFC, 8'h01); chk("R1", 15'h7FFD, 8'h01);
    chk("R1", 15'h7FFE, 8'h01); chk("R1", 15'h7FFF, 8'h00);
    wr(15'h1234, 8'h5A);
    chk("R1", 15'h1234, 8'h00); chk_sel("R1", 15'h1234, 1'b0);
    chk_sel("R1", 15'h7FF7, 1'b0); chk_sel("R1", 15'h7FF8, 1'b1);
    chk("R1", 15'h7FF9, 8'h00);

    // R6 refresh on tick
    tick();
    chk("R6", 15'h7FF9, 8'h01);

    // table: counting and rollover
    for (int i = 0; i < NV; i++) begin
      load_time(VEC[i][111-:8], VEC[i][103-:8], VEC[i][95-:8], VEC[i][87-:8],
                VEC[i][79-:8], VEC[i][71-:8], VEC[i][63-:8]);
      tick();
      for (int k = 0; k < 7; k++)
        chk($sformatf("R2-5/R13 vec%0d byte%0d", i, k + 1), 15'h7FF9 + 15'(k),
            VEC[i][55 - 8*k -: 8]);
    end

    // R7 read freeze
    load_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    wr(A_CTL, 8'h40);
    chk("R7", A_CTL, 8'h40);
    tick(); tick(); tick();
    chk("R7", 15'h7FF9, 8'h10);
    wr(A_CTL, 8'h00);
    chk("R7", 15'h7FF9, 8'h10);
    tick();
    chk("R7", 15'h7FF9, 8'h14);

    // R8 write freeze and load
    wr(A_CTL, 8'h80);
    wr(15'h7FF9, 8'h30);
    tick();
    chk("R8", 15'h7FF9, 8'h30);
    wr(A_CTL, 8'h00);
    tick();
    chk("R8", 15'h7FF9, 8'h31);
    chk("R8", 15'h7FFA, 8'h00);

    // R9 stop
    load_time(8'h85, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    tick(); tick(); tick();
    chk("R9", 15'h7FF9, 8'h85);
    wr(15'h7FF9, 8'h05);
    tick();
    chk("R9", 15'h7FF9, 8'h06);

    // R10 century flag
    load_time(8'h59, 8'h59, 8'h23, 8'h21, 8'h31, 8'h12, 8'h99);
    tick();
    chk("R10", 15'h7FFC, 8'h32); chk("R10", 15'h7FFF, 8'h00);
    load_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h12, 8'h99);
    tick();
    chk("R10", 15'h7FFC, 8'h02);

    // R11 write guard on flag, enable always writable
    wr(15'h7FFC, 8'h15);
    chk("R11", 15'h7FFC, 8'h05);
    wr(15'h7FFC, 8'h25);
    chk("R11", 15'h7FFC, 8'h25);
    wr(A_CTL, 8'h80);
    wr(15'h7FFC, 8'h15);
    chk("R11", 15'h7FFC, 8'h15);
    wr(A_CTL, 8'h00);

    // R12 reserved bits
    load_time(8'h10, 8'h85, 8'hC5, 8'hC9, 8'hC7, 8'hE3, 8'h50);
    tick();
    chk("R12", 15'h7FF9, 8'h11); chk("R12", 15'h7FFA, 8'h85);
    chk("R12", 15'h7FFB, 8'hC5); chk("R12", 15'h7FFC, 8'hC9);
    chk("R12", 15'h7FFD, 8'hC7); chk("R12", 15'h7FFE, 8'hE3);
    wr(A_CTL, 8'h2A);
    chk("R12", A_CTL, 8'h2A);
    wr(A_CTL, 8'h00);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule